// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block is the combinational hazard control for a five-stage integer pipeline (fetch, decode, execute, memory, writeback). For each of the two ALU operands of the instruction now in execute, it picks where the value comes from. The choices are the value read from the register file, the result held in the execute/memory pipeline register, or the result held in the memory/writeback pipeline register. When the two later stages both hold a result for the same register, the younger one, from the execute/memory register, wins. Register 0 is never bypassed, and a stage whose write enable is low is never bypassed.

The block also detects a load in execute whose destination the instruction in decode reads. Bypassing cannot cover that case, because the loaded data only exists after the memory stage. The block then freezes the program counter, freezes the fetch/decode register, and turns the decode/execute entry into a bubble, which is a no-op with every control bit cleared. The pipeline around the block carries the source and destination register numbers of each instruction, along with its write-enable and memory-read flags, and feeds them in.

The register file is assumed to write in the first half of a cycle and read in the second half. A result three instructions older therefore needs no bypass.

Top module: `fwd_hazard_unit`

## Requirements
- R1: When the execute/memory stage writes a nonzero register equal to an operand's source register, that operand's select is 2'b10.
- R2: When only the memory/writeback stage writes a nonzero register equal to the operand's source, the select is 2'b01.
- R3: When both stages match the same source register, the select is 2'b10 (the younger result wins).
- R4: With no matching writer, or with the matching stage's write enable low, the select is 2'b00 (register file); the code 2'b11 never appears.
- R5: A destination of register 0 is never bypassed, even with its write enable high.
- R6: Operand A follows the execute source register `ex_src_a` and operand B follows `ex_src_b`, each independently of the other.
- R7: When the execute instruction is a load to a nonzero register equal to a decode source that is marked as used, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1.
- R8: There is no stall when the execute instruction is not a load, when the matching decode source is marked unused, or when the load's destination is register 0.
- R9: The three stall outputs are always equal to each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_AW | First source register of the instruction in decode |
| id_src_b | input | REG_AW | Second source register of the instruction in decode |
| id_use_a | input | 1 | Decode instruction reads its first source |
| id_use_b | input | 1 | Decode instruction reads its second source |
| ex_src_a | input | REG_AW | First source register of the instruction in execute |
| ex_src_b | input | REG_AW | Second source register of the instruction in execute |
| ex_dst | input | REG_AW | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| exm_dst | input | REG_AW | Destination held in the execute/memory register |
| exm_wr_en | input | 1 | Execute/memory instruction writes a register |
| mwb_dst | input | REG_AW | Destination held in the memory/writeback register |
| mwb_wr_en | input | 1 | Memory/writeback instruction writes a register |
| op_a_sel | output | 2 | Source code for ALU operand A |
| op_b_sel | output | 2 | Source code for ALU operand B |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The bench builds the block with the default 5-bit register number, so register 31 and register 0 both serve as directed corner cases. Random register numbers are drawn mostly from 0 to 3. This makes matches with both later stages, double matches that test the priority rule, and register-0 writers common, while the flags stay random. Directed cases add the two-stage match, a load feeding each decode operand, a load whose matching operand is unused, and a load to register 0.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   typedef enum logic [1:0] {
      SRC_REGFILE = 2'b00,
      SRC_MEMWB   = 2'b01,
      SRC_EXMEM   = 2'b10
   } opsel_e;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
   import fwd_pkg::*;
#(
   parameter int REG_AW     = 5,
   parameter bit HARD_ZERO  = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] exm_dst,
   input  logic              exm_wr_en,
   input  logic [REG_AW-1:0] mwb_dst,
   input  logic              mwb_wr_en,
   output opsel_e            sel
);
   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   logic exm_live;
   logic mwb_live;
   logic exm_hit;
   logic mwb_hit;

   generate
      if (HARD_ZERO) begin : g_zero_fixed
         assign exm_live = exm_wr_en && (exm_dst != ZERO_REG);
         assign mwb_live = mwb_wr_en && (mwb_dst != ZERO_REG);
      end else begin : g_zero_plain
         assign exm_live = exm_wr_en;
         assign mwb_live = mwb_wr_en;
      end
   endgenerate

   assign exm_hit = exm_live && (exm_dst == src);
   assign mwb_hit = mwb_live && (mwb_dst == src);

   always_comb begin
      if (exm_hit)      sel = SRC_EXMEM;
      else if (mwb_hit) sel = SRC_MEMWB;
      else              sel = SRC_REGFILE;
   end

   always_comb begin
      assert_legal_code_R4: assert (sel != 2'b11);
      assert_memwb_source_R2: assert ((sel != SRC_MEMWB) || (mwb_wr_en && mwb_dst == src));
      assert_exmem_source_R1: assert ((sel != SRC_EXMEM) || (exm_wr_en && exm_dst == src));
      if (HARD_ZERO) begin
         assert_no_zero_bypass_R5: assert ((sel == SRC_REGFILE) || (src != ZERO_REG));
      end
   end
endmodule

// File: rtl/fwd_load_use.sv
module fwd_load_use #(
   parameter int REG_AW    = 5,
   parameter bit HARD_ZERO = 1'b1
) (
   input  logic [REG_AW-1:0] id_src_a,
   input  logic [REG_AW-1:0] id_src_b,
   input  logic              id_use_a,
   input  logic              id_use_b,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_is_load,
   output logic              stall
);
   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   logic load_live;
   logic dep_a;
   logic dep_b;

   generate
      if (HARD_ZERO) begin : g_zero_fixed
         assign load_live = ex_is_load && (ex_dst != ZERO_REG);
      end else begin : g_zero_plain
         assign load_live = ex_is_load;
      end
   endgenerate

   assign dep_a = id_use_a && (id_src_a == ex_dst);
   assign dep_b = id_use_b && (id_src_b == ex_dst);
   assign stall = load_live && (dep_a || dep_b);

   always_comb begin
      assert_stall_needs_load_R8: assert (!stall || ex_is_load);
      assert_stall_needs_use_R8: assert (!stall || id_use_a || id_use_b);
   end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
   import fwd_pkg::*;
#(
   parameter int REG_AW    = 5,
   parameter bit HARD_ZERO = 1'b1
) (
   input  logic [REG_AW-1:0] id_src_a,
   input  logic [REG_AW-1:0] id_src_b,
   input  logic              id_use_a,
   input  logic              id_use_b,
   input  logic [REG_AW-1:0] ex_src_a,
   input  logic [REG_AW-1:0] ex_src_b,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] exm_dst,
   input  logic              exm_wr_en,
   input  logic [REG_AW-1:0] mwb_dst,
   input  logic              mwb_wr_en,
   output logic [1:0]        op_a_sel,
   output logic [1:0]        op_b_sel,
   output logic              pc_hold,
   output logic              ifid_hold,
   output logic              idex_bubble
);
   localparam int NUM_OPS = 2;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_width
         $error("fwd_hazard_unit: REG_AW must lie in 1..8");
      end
   endgenerate

   logic [REG_AW-1:0] ex_src [NUM_OPS];
   opsel_e            op_sel [NUM_OPS];
   logic              stall;

   assign ex_src[0] = ex_src_a;
   assign ex_src[1] = ex_src_b;

   generate
      for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
         fwd_operand_sel #(
            .REG_AW    (REG_AW),
            .HARD_ZERO (HARD_ZERO)
         ) u_sel (
            .src       (ex_src[i]),
            .exm_dst   (exm_dst),
            .exm_wr_en (exm_wr_en),
            .mwb_dst   (mwb_dst),
            .mwb_wr_en (mwb_wr_en),
            .sel       (op_sel[i])
         );
      end
   endgenerate

   assign op_a_sel = op_sel[0];
   assign op_b_sel = op_sel[1];

   fwd_load_use #(
      .REG_AW    (REG_AW),
      .HARD_ZERO (HARD_ZERO)
   ) u_load_use (
      .id_src_a   (id_src_a),
      .id_src_b   (id_src_b),
      .id_use_a   (id_use_a),
      .id_use_b   (id_use_b),
      .ex_dst     (ex_dst),
      .ex_is_load (ex_is_load),
      .stall      (stall)
   );

   assign pc_hold     = stall;
   assign ifid_hold   = stall;
   assign idex_bubble = stall;

   always_comb begin
      assert_stall_agree_R9: assert ((pc_hold == ifid_hold) && (ifid_hold == idex_bubble));
      assert_prio_R3: assert (!(exm_wr_en && exm_dst == ex_src_a && exm_dst != '0)
                              || op_a_sel == 2'b10);
   end
endmodule

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb_top;
   localparam int AW = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [AW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, exm_dst, mwb_dst;
   logic id_use_a, id_use_b, ex_is_load, exm_wr_en, mwb_wr_en;
   logic [1:0] op_a_sel, op_b_sel;
   logic pc_hold, ifid_hold, idex_bubble;

   int n_tests = 0;
   int n_fail  = 0;

   fwd_hazard_unit #(.REG_AW(AW), .HARD_ZERO(1'b1)) dut_i (
      .id_src_a(id_src_a), .id_src_b(id_src_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
      .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst), .ex_is_load(ex_is_load),
      .exm_dst(exm_dst), .exm_wr_en(exm_wr_en), .mwb_dst(mwb_dst), .mwb_wr_en(mwb_wr_en),
      .op_a_sel(op_a_sel), .op_b_sel(op_b_sel),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble));

   function automatic logic [1:0] exp_sel(logic [AW-1:0] s);
      if (exm_wr_en && exm_dst != 0 && exm_dst == s) return 2'b10;
      if (mwb_wr_en && mwb_dst != 0 && mwb_dst == s) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic exp_stall();
      return ex_is_load && ex_dst != 0 &&
             ((id_use_a && id_src_a == ex_dst) || (id_use_b && id_src_b == ex_dst));
   endfunction

   task automatic check(string req, logic [3:0] act, logic [3:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      logic st;
      st = exp_stall();
      check({tag, " R1/R2/R3/R4/R6 op A"}, {2'b0, op_a_sel}, {2'b0, exp_sel(ex_src_a)});
      check({tag, " R6 op B"}, {2'b0, op_b_sel}, {2'b0, exp_sel(ex_src_b)});
      check({tag, " R7/R8 stall"}, {1'b0, pc_hold, ifid_hold, idex_bubble}, {1'b0, st, st, st});
   endtask

   task automatic apply(logic [AW-1:0] ia, logic [AW-1:0] ib, logic ua, logic ub,
                        logic [AW-1:0] xa, logic [AW-1:0] xb, logic [AW-1:0] xd, logic ld,
                        logic [AW-1:0] md, logic mw, logic [AW-1:0] wd, logic ww);
      @(negedge clk);
      id_src_a = ia; id_src_b = ib; id_use_a = ua; id_use_b = ub;
      ex_src_a = xa; ex_src_b = xb; ex_dst = xd; ex_is_load = ld;
      exm_dst = md; exm_wr_en = mw; mwb_dst = wd; mwb_wr_en = ww;
      #2;
   endtask

   initial begin
      #1_000_000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      // idle state
      apply(0,0,0,0, 0,0,0,0, 0,0,0,0);
      check("R4 idle A", {2'b0, op_a_sel}, 4'h0);
      check("R9 idle stall", {1'b0, pc_hold, ifid_hold, idex_bubble}, 4'h0);
      // R1 execute/memory match on A only
      apply(1,2,1,1, 7,9,3,0, 7,1,0,0);
      check("R1 exm to A", {2'b0, op_a_sel}, 4'h2);
      check("R6 B untouched", {2'b0, op_b_sel}, 4'h0);
      // R2 memory/writeback match on B only
      apply(1,2,1,1, 4,31,3,0, 0,0,31,1);
      check("R2 mwb to B", {2'b0, op_b_sel}, 4'h1);
      // R3 both stages match
      apply(1,2,1,1, 6,6,3,0, 6,1,6,1);
      check("R3 priority A", {2'b0, op_a_sel}, 4'h2);
      check("R3 priority B", {2'b0, op_b_sel}, 4'h2);
      // R4 write enable low
      apply(1,2,1,1, 6,6,3,0, 6,0,6,0);
      check("R4 wr_en low", {2'b0, op_a_sel}, 4'h0);
      // R5 register zero
      apply(1,2,1,1, 0,0,3,0, 0,1,0,1);
      check("R5 zero A", {2'b0, op_a_sel}, 4'h0);
      check("R5 zero B", {2'b0, op_b_sel}, 4'h0);
      // R7 load feeding each decode operand
      apply(5,2,1,1, 1,1,5,1, 0,0,0,0);
      check("R7 load to A", {1'b0, pc_hold, ifid_hold, idex_bubble}, 4'h7);
      apply(1,5,1,1, 1,1,5,1, 0,0,0,0);
      check("R7 load to B", {1'b0, pc_hold, ifid_hold, idex_bubble}, 4'h7);
      // R8 operand unused, not a load, load to r0
      apply(5,2,0,1, 1,1,5,1, 0,0,0,0);
      check("R8 unused", {1'b0, pc_hold, ifid_hold, idex_bubble}, 4'h0);
      apply(5,5,1,1, 1,1,5,0, 0,0,0,0);
      check("R8 not load", {1'b0, pc_hold, ifid_hold, idex_bubble}, 4'h0);
      apply(0,0,1,1, 1,1,0,1, 0,0,0,0);
      check("R8 load r0", {1'b0, pc_hold, ifid_hold, idex_bubble}, 4'h0);
      // random, registers mostly 0..3
      for (int i = 0; i < 400; i++) begin
         apply(AW'($urandom_range(0,3)), AW'($urandom_range(0,3)),
               1'($urandom), 1'($urandom),
               AW'($urandom_range(0,3)), AW'($urandom_range(0,3)),
               AW'($urandom_range(0,3)), 1'($urandom),
               AW'($urandom_range(0,3)), 1'($urandom),
               AW'($urandom_range(0,3)), 1'($urandom));
         check_all("rand");
         check("R9 agree", {3'b0, (pc_hold == ifid_hold) && (ifid_hold == idex_bubble)}, 4'h1);
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule